// File: doc/BRIEF.md
# Asynchronous byte-wide parallel bus master

This block runs the host side of an asynchronous, SRAM-style peripheral bus with an 8-bit address, 8 bits of data, and three active-low controls: chip select, write strobe and read strobe. A request names a direction, an address and a byte count. The block then walks the bus through the address, select and strobe phases. Write bytes come in on a valid/ready byte stream, and read bytes go out on a second one. A one-cycle done pulse marks the end of each request.

A request of length 1 is a plain single access. A longer request is a burst that keeps chip select low and the address steady while only the active strobe pulses once per byte. This suits peripherals that expose a FIFO behind one address. The strobe low time, and the minimum strobe high time between burst bytes, come from configuration inputs that are sampled when a request is accepted. The bus pins are decoded from state flops, and the data output enable is its own register.

Top module: `pbus_master`

## Requirements
- R1: After reset and whenever no request is in progress, bus_cs_n, bus_wr_n and bus_rd_n are 1, bus_oe is 0 and req_ready is 1.
- R2: In a write, the requested address is on bus_addr for at least one cycle with bus_cs_n high before bus_cs_n falls. bus_cs_n is low in the cycle before each fall of bus_wr_n. bus_oe is 1 and bus_cs_n is 0 in every cycle where bus_wr_n is 0.
- R3: Each write strobe stays low for exactly max(cfg_wr_ticks,1) cycles. The byte on bus_dout during the strobe equals the byte taken from the write stream, in stream order.
- R4: In a read, bus_cs_n and bus_rd_n fall in the same cycle. Each read strobe stays low for exactly max(cfg_rd_ticks,1) cycles. bus_oe is never 1 while bus_rd_n is 0, and the two strobes are never low together.
- R5: Read data is taken from bus_din in the last low cycle of each read strobe and delivered on rd_byte in bus order.
- R6: A request of N≥1 bytes lowers bus_cs_n exactly once, keeps bus_addr equal to the requested address while bus_cs_n is low, and produces N strobes. Between strobes the strobe stays high for at least max(cfg_gap_ticks,1) cycles.
- R7: A request with req_len = 0 never lowers bus_cs_n, and done is 1 in the cycle after acceptance.
- R8: While a request is in progress req_ready is 0. A request presented during that time is ignored and produces no strobe.
- R9: done is 1 for exactly one cycle per request, and only after all three controls are high again. In that cycle bus_oe is 0.
- R10: A read strobe does not begin until every previously read byte has been accepted on the read stream (rd_valid with rd_ready).
- R11: req_ready is 0 in the done cycle, so at least one idle cycle separates back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_ticks | input | 4 | Write strobe low cycles (0 acts as 1) |
| cfg_rd_ticks | input | 4 | Read strobe low cycles (0 acts as 1) |
| cfg_gap_ticks | input | 4 | Minimum strobe high cycles between burst bytes (0 acts as 1) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Target address |
| req_len | input | 8 | Byte count, 0 to 255 |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_byte | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_byte | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | 8 | Bus address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dout | output | 8 | Data driven toward the peripheral |
| bus_oe | output | 1 | Enable for the bus_dout drivers |
| bus_din | input | 8 | Data returned by the peripheral |

## Verification
A wrong sequencer state shows at the pins within one cycle. Either a strobe runs too long or too short, which changes the measured low width on the very next rising strobe, or chip select rises in the middle of a burst, which changes the per-request select count. A broken byte counter shows as a wrong strobe count or a missing done pulse by the end of the request. A misplaced enable register shows as the data drivers being on while the read strobe is low, or off during a write strobe, in the cycle it happens. The bench models the peripheral so that each read byte differs, which lets a sample taken in the wrong cycle show up as a data mismatch.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CSW, S_WSTB, S_WGAP, S_WREL,
    S_RSTB, S_RPSH, S_RGAP, S_DONE
  } pbm_state_e;
endpackage

// File: rtl/pbm_timer.sv
module pbm_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == TW'(1));
endmodule

// File: rtl/pbm_seq.sv
module pbm_seq
  import pbm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int LW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_wr_ticks,
  input  logic [TW-1:0] cfg_rd_ticks,
  input  logic [TW-1:0] cfg_gap_ticks,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_byte,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_byte,
  output logic          done,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] dout_q,
  output pbm_state_e    state_q,
  output pbm_state_e    state_nxt,
  output logic          last_byte,
  output logic          accept,
  output logic [TW-1:0] wr_ticks_q
);
  function automatic logic [TW-1:0] ticks_eff(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  logic          is_wr_q;
  logic [LW-1:0] rem_q;
  logic [TW-1:0] rd_ticks_q, gap_ticks_q;
  logic [DW-1:0] rbuf_q;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          byte_end;

  pbm_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expire(tmr_exp)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_byte = (rem_q == LW'(1));
  assign wr_ready  = (state_q == S_CSW);
  assign rd_valid  = (state_q == S_RPSH);
  assign rd_byte   = rbuf_q;
  assign done      = (state_q == S_DONE);
  assign byte_end  = ((state_q == S_WSTB) && tmr_exp) || ((state_q == S_RPSH) && rd_ready);

  always_comb begin
    state_nxt = state_q;
    tmr_load  = 1'b0;
    tmr_val   = wr_ticks_q;
    case (state_q)
      S_IDLE: if (accept) state_nxt = (req_len == '0) ? S_DONE : S_ADDR;
      S_ADDR: begin
        tmr_load = !is_wr_q;
        tmr_val  = rd_ticks_q;
        state_nxt = is_wr_q ? S_CSW : S_RSTB;
      end
      S_CSW: if (wr_valid) begin
        state_nxt = S_WSTB;
        tmr_load  = 1'b1;
      end
      S_WSTB: if (tmr_exp) begin
        state_nxt = last_byte ? S_WREL : S_WGAP;
        tmr_load  = !last_byte;
        tmr_val   = gap_ticks_q;
      end
      S_WGAP: if (tmr_exp) state_nxt = S_CSW;
      S_WREL: state_nxt = S_DONE;
      S_RSTB: if (tmr_exp) state_nxt = S_RPSH;
      S_RPSH: if (rd_ready) begin
        state_nxt = last_byte ? S_DONE : S_RGAP;
        tmr_load  = !last_byte;
        tmr_val   = gap_ticks_q;
      end
      S_RGAP: if (tmr_exp) begin
        state_nxt = S_RSTB;
        tmr_load  = 1'b1;
        tmr_val   = rd_ticks_q;
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      is_wr_q     <= 1'b0;
      addr_q      <= '0;
      rem_q       <= '0;
      wr_ticks_q  <= TW'(1);
      rd_ticks_q  <= TW'(1);
      gap_ticks_q <= TW'(1);
      dout_q      <= '0;
      rbuf_q      <= '0;
    end else begin
      state_q <= state_nxt;
      if (accept) begin
        is_wr_q     <= req_write;
        addr_q      <= req_addr;
        rem_q       <= req_len;
        wr_ticks_q  <= ticks_eff(cfg_wr_ticks);
        rd_ticks_q  <= ticks_eff(cfg_rd_ticks);
        gap_ticks_q <= ticks_eff(cfg_gap_ticks);
      end else if (byte_end) begin
        rem_q <= rem_q - 1'b1;
      end
      if ((state_q == S_CSW) && wr_valid) dout_q <= wr_byte;
      if ((state_q == S_RSTB) && tmr_exp) rbuf_q <= bus_din;
    end
  end

  // R9 / R11: done lasts one cycle and blocks acceptance while high
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  // R8: an accepted request makes the block busy in the next cycle
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R10: no new read strobe while a read byte waits on the stream
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
endmodule

// File: rtl/pbm_pins.sv
module pbm_pins
  import pbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pbm_state_e state_q,
  input  pbm_state_e state_nxt,
  input  logic       last_byte,
  output logic       bus_cs_n,
  output logic       bus_wr_n,
  output logic       bus_rd_n,
  output logic       bus_oe
);
  logic sel_on;

  always_comb begin
    case (state_q)
      S_CSW, S_WSTB, S_WGAP, S_RSTB, S_RGAP: sel_on = 1'b1;
      S_RPSH:                                sel_on = !last_byte;
      default:                               sel_on = 1'b0;
    endcase
  end

  assign bus_cs_n = !sel_on;
  assign bus_wr_n = (state_q != S_WSTB);
  assign bus_rd_n = (state_q != S_RSTB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_oe <= 1'b0;
    else        bus_oe <= (state_nxt == S_WSTB) || (state_nxt == S_WGAP) || (state_nxt == S_WREL);
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (bus_cs_n && bus_wr_n && bus_rd_n && !bus_oe));
  assert_wr_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> (!bus_cs_n && bus_oe));
  assert_no_drive_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int LW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_wr_ticks,
  input  logic [TW-1:0] cfg_rd_ticks,
  input  logic [TW-1:0] cfg_gap_ticks,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_byte,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_byte,
  output logic          done,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);
  localparam int RW = TW + 1;

  pbm_state_e    state_q, state_nxt;
  logic          last_byte, accept;
  logic [TW-1:0] wr_ticks_q;

  pbm_seq #(.AW(AW), .DW(DW), .LW(LW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_ticks(cfg_wr_ticks), .cfg_rd_ticks(cfg_rd_ticks), .cfg_gap_ticks(cfg_gap_ticks),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte),
    .done(done), .bus_din(bus_din),
    .addr_q(bus_addr), .dout_q(bus_dout),
    .state_q(state_q), .state_nxt(state_nxt),
    .last_byte(last_byte), .accept(accept), .wr_ticks_q(wr_ticks_q)
  );

  pbm_pins u_pins (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_nxt(state_nxt),
    .last_byte(last_byte),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_oe(bus_oe)
  );

  // Pin-level observers feeding the checks below
  logic [RW-1:0] wr_run_q;
  logic          zero_req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run_q   <= '0;
      zero_req_q <= 1'b0;
    end else begin
      wr_run_q   <= bus_wr_n ? '0 : wr_run_q + 1'b1;
      zero_req_q <= accept && (req_len == '0);
    end
  end

  assert_wr_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_n && wr_run_q != '0) |-> (wr_run_q == RW'(wr_ticks_q)));
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req_q |-> (done && bus_cs_n));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_cs_n && bus_wr_n && bus_rd_n && !bus_oe));
endmodule

// File: tb/pbus_master_tb_top.sv
`timescale 1ns/1ps
module pbus_master_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [3:0] cfg_wr_ticks, cfg_rd_ticks, cfg_gap_ticks;
  logic       req_valid, req_ready, req_write;
  logic [7:0] req_addr, req_len;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_byte;
  logic       rd_valid, rd_ready;
  logic [7:0] rd_byte;
  logic       done;
  logic [7:0] bus_addr, bus_dout, bus_din;
  logic       bus_cs_n, bus_wr_n, bus_rd_n, bus_oe;

  pbus_master dut_i (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    if (v == 0) return 1;
    return v;
  endfunction

  // Stimulus and peripheral model state
  logic [7:0] exp_addr = 8'h00, wbase = 8'h00, rseed = 8'h00;
  logic       stall = 1'b0;
  int widx, rd_rises, nw, nr, rcnt, cs_falls, cs_rd_same, done_cnt;
  int wr_run, rd_run, gap_run, min_gap;
  int order_err, oe_err, addr_err, drive_err, bp_err, pre_err;
  logic [7:0] last_dout, p_addr;
  int wr_len[16], rd_len[16];
  logic [7:0] wr_dat[16], rcap[16];
  logic p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1;

  assign wr_valid = 1'b1;
  assign wr_byte  = wbase + 8'(widx);
  assign bus_din  = rseed + 8'(rd_rises);

  always @(negedge clk) rd_ready <= stall ? ~rd_ready : 1'b1;

  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      widx <= 0; rd_rises <= 0; nw <= 0; nr <= 0; rcnt <= 0;
      cs_falls <= 0; cs_rd_same <= 0; done_cnt <= 0;
      wr_run <= 0; rd_run <= 0; gap_run <= 0; min_gap <= 255;
      order_err <= 0; oe_err <= 0; addr_err <= 0; drive_err <= 0; bp_err <= 0; pre_err <= 0;
    end else begin
      if (wr_valid && wr_ready) widx <= widx + 1;
      if (rd_valid && rd_ready) begin rcap[rcnt % 16] <= rd_byte; rcnt <= rcnt + 1; end
      if (done) done_cnt <= done_cnt + 1;
      if (bus_oe && !bus_rd_n) drive_err <= drive_err + 1;
      if (p_cs && !bus_cs_n) begin
        cs_falls <= cs_falls + 1;
        if (!bus_rd_n) cs_rd_same <= cs_rd_same + 1;
        if (p_addr != exp_addr) pre_err <= pre_err + 1;
      end
      if (!bus_cs_n && bus_addr != exp_addr) addr_err <= addr_err + 1;
      if (!bus_wr_n) begin
        wr_run <= wr_run + 1; last_dout <= bus_dout;
        if (!bus_oe || bus_cs_n) oe_err <= oe_err + 1;
        if (p_wr && p_cs) order_err <= order_err + 1;
      end else if (!p_wr) begin
        wr_len[nw % 16] <= wr_run; wr_dat[nw % 16] <= last_dout; nw <= nw + 1; wr_run <= 0;
      end
      if (!bus_rd_n) begin
        rd_run <= rd_run + 1;
        if (p_rd && rd_rises != rcnt) bp_err <= bp_err + 1;
      end else if (!p_rd) begin
        rd_len[nr % 16] <= rd_run; nr <= nr + 1; rd_run <= 0; rd_rises <= rd_rises + 1;
      end
      if (bus_wr_n && bus_rd_n) gap_run <= gap_run + 1;
      else begin
        if ((p_wr && p_rd) && (nw + nr) != 0 && gap_run < min_gap) min_gap <= gap_run;
        gap_run <= 0;
      end
    end
    p_cs <= bus_cs_n; p_wr <= bus_wr_n; p_rd <= bus_rd_n; p_addr <= bus_addr;
  end

  task automatic start_req(input logic w, input logic [7:0] a, input logic [7:0] n,
                           input logic [3:0] ww, input logic [3:0] rw, input logic [3:0] gw,
                           input logic st);
    @(negedge clk);
    cfg_wr_ticks = ww; cfg_rd_ticks = rw; cfg_gap_ticks = gw;
    req_write = w; req_addr = a; req_len = n; stall = st;
    exp_addr = a; wbase = a ^ 8'h5A; rseed = a ^ 8'hC3;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    chk(done, {tag, " R9 done seen"}, int'(done), 1);
  endtask

  // Vector: {pad[1:0], stall, write, addr[7:0], len[7:0], ww[3:0], rw[3:0], gw[3:0]}
  localparam logic [31:0] VEC [8] = '{
    {2'b0, 1'b0, 1'b1, 8'h3C, 8'd1, 4'd5,  4'd6,  4'd1},
    {2'b0, 1'b0, 1'b0, 8'h81, 8'd1, 4'd5,  4'd6,  4'd1},
    {2'b0, 1'b0, 1'b1, 8'h47, 8'd5, 4'd3,  4'd6,  4'd2},
    {2'b0, 1'b0, 1'b0, 8'h90, 8'd4, 4'd5,  4'd2,  4'd3},
    {2'b0, 1'b0, 1'b1, 8'h02, 8'd2, 4'd0,  4'd6,  4'd0},
    {2'b0, 1'b1, 1'b0, 8'hE5, 8'd3, 4'd5,  4'd0,  4'd0},
    {2'b0, 1'b0, 1'b1, 8'hFF, 8'd8, 4'd15, 4'd6,  4'd1},
    {2'b0, 1'b1, 1'b0, 8'h00, 8'd6, 4'd5,  4'd15, 4'd4}
  };

  bit wd_hit = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    cfg_wr_ticks = 4'd5; cfg_rd_ticks = 4'd6; cfg_gap_ticks = 4'd1; rd_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_cs_n && bus_wr_n && bus_rd_n, "R1 controls high after reset", int'(bus_cs_n), 1);
    chk(!bus_oe, "R1 oe low after reset", int'(bus_oe), 0);
    chk(req_ready && !done, "R1 ready after reset", int'(req_ready), 1);

    foreach (VEC[i]) begin
      logic [31:0] v = VEC[i];
      logic w = v[28];
      int n = int'(v[19:12]);
      int ww = int'(v[11:8]), rw = int'(v[7:4]), gw = int'(v[3:0]);
      start_req(w, v[27:20], v[19:12], v[11:8], v[7:4], v[3:0], v[29]);
      req_valid = 1'b0;
      wait_done("vec");
      chk(bus_cs_n && bus_wr_n && bus_rd_n && !bus_oe, "R9 pins idle at done", int'(bus_oe), 0);
      chk(!req_ready, "R11 not ready in done cycle", int'(req_ready), 0);
      @(negedge clk);
      chk(!done && req_ready, "R1 idle after done", int'(req_ready), 1);
      chk(done_cnt == 1, "R9 one done cycle", done_cnt, 1);
      chk(cs_falls == 1, "R6 single select", cs_falls, 1);
      chk(addr_err == 0 && pre_err == 0, "R6 address held", addr_err + pre_err, 0);
      if (n > 1) chk(min_gap >= eff(gw), "R6 strobe high gap", min_gap, eff(gw));
      if (w) begin
        chk(nw == n && nr == 0, "R6 write strobe count", nw, n);
        chk(order_err == 0 && oe_err == 0, "R2 select before strobe, data driven", order_err + oe_err, 0);
        for (int b = 0; b < n; b++) begin
          chk(wr_len[b] == eff(ww), "R3 write strobe width", wr_len[b], eff(ww));
          chk(wr_dat[b] == 8'(wbase + 8'(b)), "R3 write byte", int'(wr_dat[b]), int'(8'(wbase + 8'(b))));
        end
      end else begin
        chk(nr == n && nw == 0, "R6 read strobe count", nr, n);
        chk(cs_rd_same == 1, "R4 select and read strobe together", cs_rd_same, 1);
        chk(drive_err == 0, "R4 no drive during read", drive_err, 0);
        chk(bp_err == 0, "R10 read waits for stream", bp_err, 0);
        chk(rcnt == n, "R5 read bytes delivered", rcnt, n);
        for (int b = 0; b < n; b++) begin
          chk(rd_len[b] == eff(rw), "R4 read strobe width", rd_len[b], eff(rw));
          chk(rcap[b] == 8'(rseed + 8'(b)), "R5 read byte", int'(rcap[b]), int'(8'(rseed + 8'(b))));
        end
      end
    end

    // R7: zero-length request
    start_req(1'b1, 8'h66, 8'd0, 4'd5, 4'd6, 4'd1, 1'b0);
    req_valid = 1'b0;
    chk(done, "R7 done one cycle after accept", int'(done), 1);
    chk(bus_cs_n, "R7 select stays high", int'(bus_cs_n), 1);
    @(negedge clk);
    chk(cs_falls == 0 && !done, "R7 no select at all", cs_falls, 0);

    // R8: request held while busy is ignored
    start_req(1'b0, 8'h2B, 8'd2, 4'd5, 4'd8, 4'd1, 1'b0);
    req_write = 1'b1; req_addr = 8'h11; req_len = 8'd3;
    chk(!req_ready, "R8 not ready while busy", int'(req_ready), 0);
    wait_done("busy");
    chk(!req_ready, "R11 not ready in done cycle", int'(req_ready), 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(nw == 0, "R8 held request produced no write strobe", nw, 0);
    chk(nr == 2, "R8 original read completed", nr, 2);
    repeat (3) @(negedge clk);
    chk(bus_cs_n && req_ready, "R8 nothing started afterwards", int'(bus_cs_n), 1);

    if (!wd_hit) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule